// File: doc/BRIEF.md
# Merge Condition Unit

This block prepares the two-way merge of one ALU channel in a six-channel wide-issue bundle. The bundle may carry up to three 32-bit condition syllables. Each syllable packs two 16-bit control half-words. The block searches those half-words for the one that enables a merge on the requested channel. It takes the predicate register that this half-word names and reads it through a 32-entry predicate read port. It can invert that value for the channel. The resulting condition picks between the two operands.

The search, decode and predicate read are combinational. The predicate index leaves the block as a read address in the same cycle, and the predicate value returns in that cycle. The found flag, error flag, condition and 64-bit merge result are registered and appear one clock later. A 32-bit merge variant replaces only the low half of the destination and keeps the old upper half.

Top module: `mrg_cond_unit`

## Requirements
- R1: Candidates are ranked by syllable order, lowest syllable first. Within a syllable, the upper half-word (bits 31:16) ranks above the lower one (bits 15:0). The highest-ranked matching half-word is selected.
- R2: Scanning stops at the first syllable whose present flag is low. No half-word of that syllable or of any later syllable can be selected, even if a later syllable is present.
- R3: A half-word matches only when bit 15 is 1 and bit 14 equals the channel's cluster. The cluster is 1 for channels 3 to 5 and 0 for channels 0 to 2.
- R4: A half-word matches only when bit (10 + lane) is set, where lane = channel mod 3.
- R5: pred_idx_o equals bits 4:0 of the selected half-word in the same cycle, with no register between.
- R6: The condition is the predicate value XOR half-word bit (7 + lane).
- R7: For a 64-bit merge (word_op_i = 0), res_o is src1_i when the condition is 1 and src2_i otherwise.
- R8: For a 32-bit merge (word_op_i = 1), res_o[31:0] is the selected operand's low half and res_o[63:32] is dst_old_i[63:32].
- R9: The lookup fails in three cases: no half-word is selected, the selected half-word's bits 6:5 are not 11, or chan_i is 6 or 7. On a failure found_o = 0, err_o = 1, cond_o = 0 and res_o = dst_old_i. On success found_o = 1 and err_o = 0.
- R10: found_o, err_o, cond_o and res_o appear one clock after their inputs. After reset they are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| syl_i | input | 96 | Condition syllables; syllable s is bits 32s+31:32s |
| syl_vld_i | input | 3 | Present flag per syllable |
| chan_i | input | 3 | ALU channel number, valid 0 to 5 |
| word_op_i | input | 1 | 1 selects the 32-bit merge variant |
| src1_i | input | 64 | Operand taken when the condition is 1 |
| src2_i | input | 64 | Operand taken when the condition is 0 |
| dst_old_i | input | 64 | Current destination value |
| pred_idx_o | output | 5 | Predicate file read address |
| pred_val_i | input | 1 | Predicate value at pred_idx_o |
| found_o | output | 1 | Registered: merge condition located |
| err_o | output | 1 | Registered: lookup failed |
| cond_o | output | 1 | Registered: effective merge condition |
| res_o | output | 64 | Registered merge result |

## Verification
The bench builds the block with its defaults: three syllables and a 64-bit datapath. Six half-word slots are therefore the whole search space.

One sweep places a single half-word in the first slot. It covers every channel code, including the two invalid ones, every mask and invert pattern, both cluster and enable values, and both predicate values. This reaches every match and inversion combination.

A second phase uses biased random syllable sets and presence patterns, plus directed cases. Together they reach ranking between slots, the stop at an absent syllable, rejected condition sources and both merge widths.

// File: rtl/mrg_pkg.sv
package mrg_pkg;
  localparam int SYL_W   = 32;
  localparam int HW_W    = 16;
  localparam int PIDX_W  = 5;
  localparam int LANES   = 3;
  localparam int NUM_CH  = 2 * LANES;
  localparam int CHAN_W  = 3;
  localparam int LANE_W  = 2;

  typedef struct packed {
    logic              hit;
    logic              src_ok;
    logic              inv;
    logic [PIDX_W-1:0] pidx;
  } hw_dec_t;

  function automatic logic chan_valid(input logic [CHAN_W-1:0] ch);
    return int'(ch) < NUM_CH;
  endfunction

  function automatic logic chan_cluster(input logic [CHAN_W-1:0] ch);
    return int'(ch) >= LANES;
  endfunction

  function automatic logic [LANE_W-1:0] chan_lane(input logic [CHAN_W-1:0] ch);
    int l;
    l = int'(ch) % LANES;
    return chan_valid(ch) ? LANE_W'(l) : '0;
  endfunction
endpackage

// File: rtl/mrg_hw_decode.sv
module mrg_hw_decode
  import mrg_pkg::*;
(
  input  logic [HW_W-1:0]   hw_i,
  input  logic [LANE_W-1:0] lane_i,
  input  logic              cluster_i,
  input  logic              chan_ok_i,
  output hw_dec_t           dec_o
);
  localparam int EN_BIT   = 15;
  localparam int CLU_BIT  = 14;
  localparam int MASK_LSB = 10;
  localparam int INV_LSB  = 7;

  logic mask_bit;
  logic inv_bit;

  always_comb begin
    mask_bit = 1'b0;
    inv_bit  = 1'b0;
    for (int l = 0; l < LANES; l++) begin
      if (lane_i == LANE_W'(l)) begin
        mask_bit = hw_i[MASK_LSB + l];
        inv_bit  = hw_i[INV_LSB + l];
      end
    end
  end

  assign dec_o.hit    = chan_ok_i & hw_i[EN_BIT] & (hw_i[CLU_BIT] == cluster_i) & mask_bit;
  assign dec_o.src_ok = (hw_i[6:5] == 2'b11);
  assign dec_o.inv    = inv_bit;
  assign dec_o.pidx   = hw_i[PIDX_W-1:0];
endmodule

// File: rtl/mrg_locator.sv
module mrg_locator
  import mrg_pkg::*;
#(
  parameter int NUM_SYL = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_SYL*SYL_W-1:0] syl_i,
  input  logic [NUM_SYL-1:0]       syl_vld_i,
  input  logic [LANE_W-1:0]        lane_i,
  input  logic                     cluster_i,
  input  logic                     chan_ok_i,
  output logic                     hit_o,
  output hw_dec_t                  sel_o
);
  localparam int NUM_HW = 2 * NUM_SYL;

  logic [NUM_SYL-1:0] reach;
  hw_dec_t            dec [NUM_HW];
  logic [NUM_HW-1:0]  cand;
  logic [NUM_HW-1:0]  first;
  logic [NUM_HW:0]    seen;

  assign seen[0] = 1'b0;

  // syllable s stays reachable only while all earlier ones are present
  for (genvar s = 0; s < NUM_SYL; s++) begin : g_reach
    if (s == 0) begin : g_head
      assign reach[s] = syl_vld_i[s];
    end else begin : g_tail
      assign reach[s] = reach[s-1] & syl_vld_i[s];
    end
  end

  // slot k: even = upper half, odd = lower half of syllable k/2
  for (genvar k = 0; k < NUM_HW; k++) begin : g_slot
    localparam int S  = k / 2;
    localparam int LO = S * SYL_W + (((k % 2) == 0) ? HW_W : 0);
    mrg_hw_decode u_dec (
      .hw_i      (syl_i[LO +: HW_W]),
      .lane_i    (lane_i),
      .cluster_i (cluster_i),
      .chan_ok_i (chan_ok_i),
      .dec_o     (dec[k])
    );
    assign cand[k]   = dec[k].hit & reach[S];
    assign first[k]  = cand[k] & ~seen[k];
    assign seen[k+1] = seen[k] | cand[k];
  end

  always_comb begin
    sel_o = '0;
    for (int k = 0; k < NUM_HW; k++) begin
      if (first[k]) sel_o = dec[k];
    end
  end

  assign hit_o = seen[NUM_HW];

  p_single_pick_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(first));
endmodule

// File: rtl/mrg_eval.sv
module mrg_eval
  import mrg_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              hit_i,
  input  hw_dec_t           dec_i,
  input  logic              pred_val_i,
  input  logic              word_op_i,
  input  logic [DATA_W-1:0] src1_i,
  input  logic [DATA_W-1:0] src2_i,
  input  logic [DATA_W-1:0] dst_old_i,
  output logic              ok_o,
  output logic              cond_o,
  output logic [DATA_W-1:0] res_o
);
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] pick;

  assign ok_o   = hit_i & dec_i.src_ok;
  assign cond_o = ok_o & (pred_val_i ^ dec_i.inv);
  assign pick   = cond_o ? src1_i : src2_i;

  always_comb begin
    if (!ok_o)          res_o = dst_old_i;
    else if (word_op_i) res_o = {dst_old_i[DATA_W-1:HALF_W], pick[HALF_W-1:0]};
    else                res_o = pick;
  end
endmodule

// File: rtl/mrg_cond_unit.sv
module mrg_cond_unit
  import mrg_pkg::*;
#(
  parameter int NUM_SYL = 3,
  parameter int DATA_W  = 64
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_SYL*SYL_W-1:0] syl_i,
  input  logic [NUM_SYL-1:0]       syl_vld_i,
  input  logic [CHAN_W-1:0]        chan_i,
  input  logic                     word_op_i,
  input  logic [DATA_W-1:0]        src1_i,
  input  logic [DATA_W-1:0]        src2_i,
  input  logic [DATA_W-1:0]        dst_old_i,
  output logic [PIDX_W-1:0]        pred_idx_o,
  input  logic                     pred_val_i,
  output logic                     found_o,
  output logic                     err_o,
  output logic                     cond_o,
  output logic [DATA_W-1:0]        res_o
);
  localparam int HALF_W = DATA_W / 2;

  logic              hit;
  hw_dec_t           sel;
  logic              ok;
  logic              cond_d;
  logic [DATA_W-1:0] res_d;

  mrg_locator #(.NUM_SYL(NUM_SYL)) u_loc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .syl_i     (syl_i),
    .syl_vld_i (syl_vld_i),
    .lane_i    (chan_lane(chan_i)),
    .cluster_i (chan_cluster(chan_i)),
    .chan_ok_i (chan_valid(chan_i)),
    .hit_o     (hit),
    .sel_o     (sel)
  );

  assign pred_idx_o = sel.pidx;

  mrg_eval #(.DATA_W(DATA_W)) u_eval (
    .hit_i      (hit),
    .dec_i      (sel),
    .pred_val_i (pred_val_i),
    .word_op_i  (word_op_i),
    .src1_i     (src1_i),
    .src2_i     (src2_i),
    .dst_old_i  (dst_old_i),
    .ok_o       (ok),
    .cond_o     (cond_d),
    .res_o      (res_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      found_o <= 1'b0;
      err_o   <= 1'b0;
      cond_o  <= 1'b0;
      res_o   <= '0;
    end else begin
      found_o <= ok;
      err_o   <= ~ok;
      cond_o  <= cond_d;
      res_o   <= res_d;
    end
  end

  p_excl_flags_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(found_o && err_o));
  p_err_keeps_dst_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chan_i > 3'd5) |=> (err_o && !cond_o && res_o == $past(dst_old_i)));
  p_sel_wide_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ok && !word_op_i) |=> (res_o == (cond_o ? $past(src1_i) : $past(src2_i))));
  p_keep_high_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ok && word_op_i) |=> (res_o[DATA_W-1:HALF_W] == $past(dst_old_i[DATA_W-1:HALF_W])));
  p_no_cond_on_err_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !cond_o);
endmodule

// File: tb/mrg_cond_unit_tb.sv
`timescale 1ns/1ps
module mrg_cond_unit_tb;
  localparam int NS = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS*32-1:0] syl = '0;
  logic [NS-1:0] vld = '0;
  logic [2:0]    chan = '0;
  logic          word_op = 1'b0;
  logic [63:0]   src1 = '0, src2 = '0, dold = '0;
  logic [4:0]    pidx;
  logic          pval;
  logic          found, err, cond;
  logic [63:0]   res;
  logic [31:0]   pfile = '0;

  int n_chk = 0;
  int n_err = 0;

  logic e_hit, e_found, e_cond;
  logic [4:0]  e_pidx;
  logic [63:0] e_res;

  always #2.5 clk = ~clk;
  assign pval = pfile[pidx];

  mrg_cond_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .syl_i(syl), .syl_vld_i(vld), .chan_i(chan),
    .word_op_i(word_op), .src1_i(src1), .src2_i(src2), .dst_old_i(dold),
    .pred_idx_o(pidx), .pred_val_i(pval), .found_o(found), .err_o(err),
    .cond_o(cond), .res_o(res)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  // reference model written from the requirement text
  task automatic model();
    logic [15:0] hw;
    logic [15:0] pick;
    int ln;
    logic cl;
    logic [63:0] m;
    e_hit = 1'b0;
    pick = '0;
    ln = int'(chan) % 3;
    cl = (chan >= 3);
    if (chan <= 5) begin
      for (int s = 0; s < NS; s++) begin
        if (!vld[s] || e_hit) break;
        for (int h = 0; h < 2; h++) begin
          hw = (h == 0) ? syl[s*32+16 +: 16] : syl[s*32 +: 16];
          if (!e_hit && hw[15] && hw[14] == cl && hw[10+ln]) begin
            e_hit = 1'b1;
            pick = hw;
          end
        end
      end
    end
    e_pidx  = pick[4:0];
    e_found = e_hit && pick[6:5] == 2'b11;
    e_cond  = e_found && (pfile[pick[4:0]] ^ pick[7+ln]);
    m = e_cond ? src1 : src2;
    if (!e_found)     e_res = dold;
    else if (word_op) e_res = {dold[63:32], m[31:0]};
    else              e_res = m;
  endtask

  task automatic run_one(input string tag);
    @(negedge clk);
    #0.5;
    model();
    if (e_hit) check({tag, " R5 pidx"}, 64'(pidx), 64'(e_pidx));
    @(posedge clk);
    #1;
    check({tag, " R9 found"}, 64'(found), 64'(e_found));
    check({tag, " R9 err"}, 64'(err), 64'(!e_found));
    check({tag, " R6 cond"}, 64'(cond), 64'(e_cond));
    check({tag, word_op ? " R8 res" : " R7 res"}, res, e_res);
  endtask

  task automatic rand_ops();
    src1 = {$urandom, $urandom};
    src2 = {$urandom, $urandom};
    dold = {$urandom, $urandom};
    pfile = $urandom;
    word_op = 1'($urandom);
  endtask

  function automatic logic [15:0] rand_hw();
    logic [15:0] h;
    h = 16'($urandom);
    if ($urandom % 4 != 0) h[15] = 1'b1;
    if ($urandom % 4 != 0) h[6:5] = 2'b11;
    return h;
  endfunction

  initial begin
    #200000;
    n_chk++;
    n_err++;
    $display("FAIL watchdog R10 act=%h exp=%h", 0, 1);
    finish_run();
  end

  initial begin
    logic [4:0] ix;
    repeat (3) @(posedge clk);
    #1;
    // R10 reset state
    check("R10 reset found", 64'(found), 0);
    check("R10 reset err", 64'(err), 0);
    check("R10 reset cond", 64'(cond), 0);
    check("R10 reset res", res, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R3 R4 R6 sweep: one half-word in the first slot
    for (int c = 0; c < 8; c++)
      for (int mk = 0; mk < 8; mk++)
        for (int cb = 0; cb < 2; cb++)
          for (int en = 0; en < 2; en++)
            for (int iv = 0; iv < 8; iv++)
              for (int pv = 0; pv < 2; pv++) begin
                @(negedge clk);
                rand_ops();
                ix = 5'($urandom);
                pfile[ix] = 1'(pv);
                chan = 3'(c);
                vld = 3'b001;
                syl = '0;
                syl[31:16] = {1'(en), 1'(cb), 1'b0, 3'(mk), 3'(iv), 2'b11, ix};
                run_one("R3 R4 sweep");
              end

    // R1 upper before lower
    @(negedge clk);
    rand_ops();
    chan = 3'd4; vld = 3'b111; syl = '0;
    syl[31:16] = 16'hC000 | 16'h0800 | 16'h0060 | 16'd7;
    syl[15:0]  = 16'hC000 | 16'h0800 | 16'h0060 | 16'd9;
    run_one("R1 upper first");
    check("R1 upper pidx", 64'(found ? e_pidx : 5'd7), 64'd7);

    // R2 absent first syllable hides later ones
    @(negedge clk);
    rand_ops();
    chan = 3'd0; vld = 3'b110; syl = '0;
    syl[63:48] = 16'h8400 | 16'h0060 | 16'd3;
    run_one("R2 gap");
    check("R2 gap err", 64'(err), 64'd1);

    // R9 source not a predicate
    @(negedge clk);
    rand_ops();
    chan = 3'd1; vld = 3'b001; syl = '0;
    syl[15:0] = 16'h8800 | 16'h0040 | 16'd2;
    run_one("R9 bad src");
    check("R9 bad src res", res, dold);

    // R1 R2 R8 random sets
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      rand_ops();
      chan = 3'($urandom % 7);
      vld = 3'($urandom);
      if ($urandom % 2 == 0) vld = 3'b111;
      for (int s = 0; s < NS; s++) syl[s*32 +: 32] = {rand_hw(), rand_hw()};
      run_one("R1 R2 random");
    end

    finish_run();
  end
endmodule